// File: doc/BRIEF.md
# Incremental ADC decimation controller

This block is the digital back end of a first-order incremental converter. A switched-capacitor integrator outside the block produces a one-bit comparator decision. The block runs on the same clock as that integrator. Each integration cycle spans four clocks. Every clock during which the comparator reads high adds one to a 14-bit accumulator, so a positive integration cycle adds four. An 8-bit prescaler wraps every 256 clocks, which is one "time cycle", and emits a tick each time it wraps. A sequencer counts those ticks.

After 64 time cycles (4096 integration cycles), the saturated count is converted to a signed 12-bit result and latched. The result is the count shifted right by two, minus 2048. A one-clock valid pulse marks the new result. The accumulator is then held clear for one further time cycle, so one conversion takes 65 × 256 = 16640 clocks.

The sequencer is a three-state machine:
- `ST_IDLE`: the block is disabled, and all counters are clear.
- `ST_ACCUM`: the window is accumulating.
- `ST_GAP`: the accumulator is held in reset.

The transitions are:
- **start** (`ST_IDLE`→`ST_ACCUM`): taken when the enable is high.
- **window done** (`ST_ACCUM`→`ST_GAP`): taken on the 64th tick. The result is latched on this transition.
- **gap done** (`ST_GAP`→`ST_ACCUM`): taken on the next tick.
- **stop** (any state→`ST_IDLE`): taken whenever the enable is low.

Top module: `incadc_decim`

## Requirements
- R1: While reset is held, and on the first clock after it, `data_o` reads 0, `valid_o` reads 0 and `tick_o` reads 0.
- R2: If the comparator is high for the 4k clocks of k integration cycles inside a window (0 ≤ k ≤ 4095), the latched result equals k − 2048 in two's complement. This holds regardless of where in the window those cycles fall.
- R3: A window with the comparator low throughout yields −2048 (bit pattern 0x800).
- R4: The count saturates at 16383 instead of wrapping, so a window with the comparator high on every clock yields +2047.
- R5: `valid_o` is high for exactly one clock. Its first assertion follows the 16384th clock edge after the edge that samples the enable high, and `data_o` carries the new result in that same cycle.
- R6: Successive `valid_o` pulses are 16640 clocks apart. The comparator value during the 256-clock gap after each window does not affect the next result.
- R7: `tick_o` pulses high for one clock after every 256 enabled clocks, giving 65 ticks per conversion period.
- R8: When the enable is low, the prescaler, tick counter and accumulator clear, and `valid_o` and `tick_o` stay low. Re-enabling starts a fresh window with the R5 timing, and earlier comparator activity leaves no trace.
- R9: `data_o` holds its last result between valid pulses and while disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Integrator clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Run enable; low stops and clears the conversion |
| comp_i | input | 1 | Comparator decision from the integrator, 1 = positive |
| data_o | output | 12 | Latched result, two's complement, −2048 to +2047 |
| valid_o | output | 1 | One-clock pulse when `data_o` takes a new result |
| tick_o | output | 1 | One-clock pulse on each prescaler wrap (every 256 clocks) |

## Verification
The assertions assume that `comp_i` and `en_i` change only between clock edges and settle before the sampling edge. They also assume that `en_i` is a level held for many clocks, not a pulse stream. The bench drives every input on the falling edge. It holds `comp_i` constant across each group of four clocks, so the stimulus mirrors a real integrator whose decision is fixed for one integration cycle. Positive cycles are placed both at the start and at the end of a window. The comparator is forced high during every gap, so any leakage of gap activity into the next result would show up as a miscompare.

// File: rtl/incadc_pkg.sv
package incadc_pkg;

    // Sequencer states of the conversion controller
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_GAP   = 2'd2
    } seq_state_e;

    // Number of bits needed to count 0..n
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/incadc_prescaler.sv
module incadc_prescaler #(
    parameter int unsigned TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    output logic [TICK_W-1:0] cnt_o,
    output logic              wrap_o
);
    localparam logic [TICK_W-1:0] CNT_LAST = {TICK_W{1'b1}};

    logic [TICK_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = run_i && (cnt_q == CNT_LAST);

    // R7: a wrap can never occur on two consecutive clocks
    p_wrap_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> !wrap_o)
        else $error("prescaler wrapped on consecutive clocks");

endmodule

// File: rtl/incadc_accum.sv
module incadc_accum #(
    parameter int unsigned ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_en_i,
    input  logic             bit_i,
    output logic [ACC_W-1:0] count_o,
    output logic [ACC_W-1:0] sum_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    logic [ACC_W-1:0] count_q;
    logic [ACC_W-1:0] sum_c;

    // Saturating sum including the current comparator decision
    always_comb begin
        if (!inc_en_i || !bit_i) begin
            sum_c = count_q;
        end else if (count_q == ACC_MAX) begin
            sum_c = ACC_MAX;
        end else begin
            sum_c = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            count_q <= '0;
        end else begin
            count_q <= sum_c;
        end
    end

    assign count_o = count_q;
    assign sum_o   = sum_c;

    // R4: once full, the count never wraps back while not cleared
    p_acc_saturate_r4: assert property (@(posedge clk) disable iff (rst)
        (count_q == ACC_MAX && !clr_i) |=> (count_q == ACC_MAX))
        else $error("accumulator wrapped past full scale");

endmodule

// File: rtl/incadc_format.sv
module incadc_format #(
    parameter int unsigned ACC_W = 14,
    parameter int unsigned OUT_W = 12
) (
    input  logic [ACC_W-1:0] sum_i,
    output logic [OUT_W-1:0] code_o
);
    localparam logic [OUT_W-1:0] MID_CODE = OUT_W'(1) << (OUT_W - 1);

    logic [OUT_W-1:0] mag;

    generate
        if (ACC_W > OUT_W) begin : g_shift
            localparam int unsigned DROP = ACC_W - OUT_W;
            assign mag = sum_i[ACC_W-1:DROP];
        end else if (ACC_W == OUT_W) begin : g_same
            assign mag = sum_i;
        end else begin : g_pad
            assign mag = {sum_i, {(OUT_W - ACC_W){1'b0}}};
        end
    endgenerate

    // Offset binary to two's complement
    assign code_o = mag - MID_CODE;

endmodule

// File: rtl/incadc_seq.sv
module incadc_seq
    import incadc_pkg::*;
#(
    parameter int unsigned WIN_TICKS = 64,
    parameter int unsigned GAP_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       wrap_i,
    output seq_state_e state_o,
    output logic       run_o,
    output logic       acc_en_o,
    output logic       acc_clr_o,
    output logic       latch_o
);
    localparam int unsigned TC_W = cnt_bits((WIN_TICKS > GAP_TICKS) ? WIN_TICKS : GAP_TICKS);
    localparam logic [TC_W-1:0] WIN_LAST = TC_W'(WIN_TICKS - 1);
    localparam logic [TC_W-1:0] GAP_LAST = TC_W'(GAP_TICKS - 1);

    seq_state_e state_q, state_d;
    logic [TC_W-1:0] tcnt_q, tcnt_d;
    logic win_done, gap_done;

    assign win_done = wrap_i && (tcnt_q == WIN_LAST);
    assign gap_done = wrap_i && (tcnt_q == GAP_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        tcnt_d  = tcnt_q;
        unique case (state_q)
            ST_IDLE: begin
                tcnt_d = '0;
                if (en_i) begin
                    state_d = ST_ACCUM;          // start
                end
            end
            ST_ACCUM: begin
                if (!en_i) begin
                    state_d = ST_IDLE;           // stop
                    tcnt_d  = '0;
                end else if (win_done) begin
                    state_d = ST_GAP;            // window done
                    tcnt_d  = '0;
                end else if (wrap_i) begin
                    tcnt_d = tcnt_q + 1'b1;
                end
            end
            ST_GAP: begin
                if (!en_i) begin
                    state_d = ST_IDLE;           // stop
                    tcnt_d  = '0;
                end else if (gap_done) begin
                    state_d = ST_ACCUM;          // gap done
                    tcnt_d  = '0;
                end else if (wrap_i) begin
                    tcnt_d = tcnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                tcnt_d  = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            tcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            tcnt_q  <= tcnt_d;
        end
    end

    // Outputs
    always_comb begin
        run_o     = 1'b0;
        acc_en_o  = 1'b0;
        acc_clr_o = 1'b1;
        latch_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run_o = 1'b0;
            end
            ST_ACCUM: begin
                run_o     = en_i;
                acc_en_o  = en_i;
                acc_clr_o = !en_i || win_done;
                latch_o   = en_i && win_done;
            end
            ST_GAP: begin
                run_o = en_i;
            end
            default: begin
                run_o = 1'b0;
            end
        endcase
    end

    assign state_o = state_q;

    // R6: the gap always leads back into accumulation, never straight to a latch
    p_gap_no_latch_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP) |=> (state_q != ST_GAP || !latch_o))
        else $error("latch raised during gap");

endmodule

// File: rtl/incadc_decim.sv
module incadc_decim
    import incadc_pkg::*;
#(
    parameter int unsigned OUT_W        = 12,
    parameter int unsigned CLKS_PER_INT = 4,
    parameter int unsigned TICK_W       = 8,
    parameter int unsigned WIN_TICKS    = 64,
    parameter int unsigned GAP_TICKS    = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             comp_i,
    output logic [OUT_W-1:0] data_o,
    output logic             valid_o,
    output logic             tick_o
);
    // Accumulator width: resolution plus the per-cycle gain of CLKS_PER_INT
    localparam int unsigned ACC_W = OUT_W + $clog2(CLKS_PER_INT);

    seq_state_e        state;
    logic              run, acc_en, acc_clr, latch, wrap;
    logic [TICK_W-1:0] presc_cnt;
    logic [ACC_W-1:0]  acc_count, acc_sum;
    logic [OUT_W-1:0]  code;

    incadc_prescaler #(.TICK_W(TICK_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .cnt_o  (presc_cnt),
        .wrap_o (wrap)
    );

    incadc_seq #(.WIN_TICKS(WIN_TICKS), .GAP_TICKS(GAP_TICKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .wrap_i    (wrap),
        .state_o   (state),
        .run_o     (run),
        .acc_en_o  (acc_en),
        .acc_clr_o (acc_clr),
        .latch_o   (latch)
    );

    incadc_accum #(.ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (acc_clr),
        .inc_en_i (acc_en),
        .bit_i    (comp_i),
        .count_o  (acc_count),
        .sum_o    (acc_sum)
    );

    incadc_format #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_fmt (
        .sum_i  (acc_sum),
        .code_o (code)
    );

    // Output registers
    logic [OUT_W-1:0] data_q;
    logic             valid_q, tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q  <= '0;
            valid_q <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            valid_q <= latch;
            tick_q  <= wrap;
            if (latch) begin
                data_q <= code;
            end
        end
    end

    assign data_o  = data_q;
    assign valid_o = valid_q;
    assign tick_o  = tick_q;

    // R5: valid is a single-clock pulse
    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o)
        else $error("valid held longer than one clock");

    // R9: the result only moves together with valid
    p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(data_o))
        else $error("data changed without valid");

    // R8: disabling silences valid and tick on the next clock
    p_disable_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (!valid_o && !tick_o))
        else $error("activity after disable");

    // R6: during the gap the accumulator stays clear
    p_gap_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> (acc_count == '0))
        else $error("accumulator not clear during gap");

    // R8: in idle the prescaler and accumulator are clear
    p_idle_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> (presc_cnt == '0 && acc_count == '0))
        else $error("idle state not clear");

endmodule

// File: tb/incadc_decim_tb.sv
module incadc_decim_tb_top;

    localparam int WIN_CLKS = 16384;
    localparam int GAP_CLKS = 256;
    localparam int NVEC     = 7;
    localparam int VEC_K [NVEC] = '{0, 1, 1000, 2048, 3000, 4095, 4096};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic        comp = 1'b0;
    logic [11:0] data;
    logic        valid, tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    incadc_decim dut_i (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en),
        .comp_i  (comp),
        .data_o  (data),
        .valid_o (valid),
        .tick_o  (tick)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expected_code(input int k);
        return ((k > 4095) ? 4095 : k) - 2048;
    endfunction

    // One step: drive at the falling edge, pass a rising edge, land on the next falling edge
    task automatic step(input logic c);
        comp = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    // One full conversion (window plus gap); placement 0 = leading, 1 = trailing
    task automatic run_conv(input int k, input bit trail, input bit chk_hold, input int prev);
        int early = 0;
        int ticks = 0;
        for (int i = 1; i <= WIN_CLKS; i++) begin
            int j = (i - 1) / 4;
            logic c = trail ? (j >= 4096 - k) : (j < k);
            step(c);
            if (tick) ticks++;
            if (i < WIN_CLKS && valid) early++;
            if (chk_hold && i == 8000)
                chk($signed(data) == prev, "R9 hold", $signed(data), prev);
        end
        chk(valid === 1'b1, "R5 valid at window end", valid, 1);
        chk(early == 0, "R5 no early valid", early, 0);
        chk($signed(data) == expected_code(k),
            (k == 0) ? "R3 zero input" : (k >= 4095) ? "R4 full scale" : "R2 result",
            $signed(data), expected_code(k));
        early = 0;
        for (int g = 1; g <= GAP_CLKS; g++) begin
            step(1'b1);   // R6: comparator during gap must be ignored
            if (tick) ticks++;
            if (valid) early++;
        end
        chk(early == 0, "R6 no valid within gap", early, 0);
        chk(ticks == 65, "R7 ticks per conversion", ticks, 65);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(data == 12'd0 && !valid && !tick, "R1 reset state", {valid, tick, data}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(data == 12'd0 && !valid && !tick, "R1 after release", {valid, tick, data}, 0);

        // Enable: the next rising edge samples it high (start transition)
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // Table walk; each conversion follows the previous one without pause (R6 period)
        for (int v = 0; v < NVEC; v++) begin
            run_conv(VEC_K[v], v[0], v > 0, (v > 0) ? expected_code(VEC_K[v-1]) : 0);
        end

        // R8: disable mid-window after heavy comparator activity
        for (int i = 0; i < 1000; i++) step(1'b1);
        en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step(1'b1);
            chk(!valid && !tick, "R8 quiet while disabled", {valid, tick}, 0);
        end
        chk($signed(data) == expected_code(VEC_K[NVEC-1]), "R9 hold while disabled",
            $signed(data), expected_code(VEC_K[NVEC-1]));
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        run_conv(5, 1'b0, 1'b0, 0);   // R8: fresh window gives exactly 5 - 2048

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule